// File: doc/BRIEF.md
# Port Interrupt-on-Change Unit

This block raises interrupts for two 8-bit input ports, called A and B. Each pin has three settings: an enable bit, a compare-mode bit and a default-value bit. A pin with its compare-mode bit clear triggers when its value differs from the value it had on the previous clock. A pin with its compare-mode bit set triggers when its value differs from its default-value bit. The pin values arrive already synchronized and already polarity-corrected.

When the first enabled pin of a port meets its condition, the block does four things:
- it sets that pin's flag bit;
- it saves the whole port value into a capture register;
- it freezes that capture register until the host clears the interrupt;
- it asserts the port's interrupt.

The host clears a port's interrupt by reading that port's capture register or its port register. Either read is signalled by a one-cycle strobe.

Each of the two interrupt outputs is presented as an output-enable and a data value, so the pad can run push-pull or open-drain. A shared configuration register sets three things: the active level, open-drain operation, and whether the two outputs mirror the OR of both ports.

Top module: `port_ioc_unit`

## Requirements
- R1: After a synchronous active-low reset, every register holds zero. So every flag and capture bit reads 0, and both interrupt outputs sit inactive: output-enable 1, data value 1, because the reset configuration is push-pull and active-low.
- R2: A pin whose enable bit is 0 never sets its flag, whatever its value does.
- R3: With its compare-mode bit 0, an enabled pin sets its own flag bit on the clock edge that first samples a value different from the value sampled on the previous edge. Flag bits stay set until cleared.
- R4: With its compare-mode bit 1, an enabled pin sets its flag while its value differs from its default-value bit. If the mismatch is still present after a clear, the flag is 0 for one cycle and then set again.
- R5: The edge that sets the first flag of an empty flag register loads the port value into that port's capture register. While any flag of that port is set, the capture register does not change. After a clear it keeps its value until the next interrupt.
- R6: A read strobe for a port's capture register or its port register clears that port's flags on the next edge. The other port is left unaffected.
- R7: With the mirror bit set, both outputs assert whenever either port has a flag set. With it clear, output A follows only port A and output B follows only port B.
- R8: In push-pull mode the output-enable is 1. The data value equals the interrupt state when the active-high bit is 1, and its inverse when that bit is 0.
- R9: With the open-drain bit set, the output-enable is 1 only while that output's interrupt is asserted, and the data value is always 0. The active-high bit has no effect in this mode.
- R10: The register map is as follows.
  - Address bit 0 selects the port: 0 for A, 1 for B.
  - Address bits 2:1 select the register: 0 for enable, 1 for compare-mode, 2 for default value.
  - Address 6 is the configuration register: bit 0 is mirror, bit 1 is open-drain, bit 2 is active-high.
  - A write takes effect on the edge that samples the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_a | input | 8 | Port A value, synchronized and polarity-corrected |
| pin_b | input | 8 | Port B value, synchronized and polarity-corrected |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select, per R10 |
| wr_data | input | 8 | Write data |
| rd_cap_a | input | 1 | Port A capture register is being read |
| rd_port_a | input | 1 | Port A port register is being read |
| rd_cap_b | input | 1 | Port B capture register is being read |
| rd_port_b | input | 1 | Port B port register is being read |
| flag_a | output | 8 | Port A flag register |
| flag_b | output | 8 | Port B flag register |
| cap_a | output | 8 | Port A capture register |
| cap_b | output | 8 | Port B capture register |
| irq_a_oe | output | 1 | Output-enable for interrupt output A |
| irq_a_val | output | 1 | Data value for interrupt output A |
| irq_b_oe | output | 1 | Output-enable for interrupt output B |
| irq_b_val | output | 1 | Data value for interrupt output B |

## Verification
The hardest situation to reach is the cycle right after a clear while a default-value mismatch is still on the pin. The flag must drop for exactly one cycle, return, and capture the port value again. The bench reaches it by holding port B away from its default value and pulsing the port-read strobe for one cycle. It then checks the flag on the cycle immediately after the clearing edge, and again on the following cycle. The capture freeze is reached by changing other pins of a port, enabled or not, while its flag is already set.

// File: rtl/ioc_pkg.sv
// Package ioc_pkg
// Holds the types shared by the interrupt-on-change unit: the register
// kind carried in the write address and the global output configuration.
package ioc_pkg;
    // Register kind, taken from write address bits 2:1
    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_MODE   = 2'd1,
        REG_DEFAULT= 2'd2,
        REG_CONFIG = 2'd3
    } ioc_reg_e;

    // Global output configuration (register at address 6)
    typedef struct packed {
        logic act_high;   // bit 2
        logic open_drain; // bit 1
        logic mirror;     // bit 0
    } ioc_cfg_t;
endpackage

// File: rtl/ioc_cfg_regs.sv
// Module ioc_cfg_regs
// Register file for the per-port enable, compare-mode and default-value
// registers, plus the global configuration.
// Assumes: address bit 0 selects the port and bits 2:1 select the kind;
// writes land on the edge that samples wr_en.
module ioc_cfg_regs
    import ioc_pkg::*;
#(
    parameter int W      = 8,
    parameter int NPORT  = 2,
    parameter int AW     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [W-1:0]               wr_data,
    output logic [NPORT-1:0][W-1:0]    en_o,
    output logic [NPORT-1:0][W-1:0]    mode_o,
    output logic [NPORT-1:0][W-1:0]    def_o,
    output ioc_cfg_t                   cfg_o
);
    localparam int CFGW = $bits(ioc_cfg_t);

    ioc_reg_e kind;
    assign kind = ioc_reg_e'(wr_addr[2:1]);

    // Per-port registers, one set per port
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic hit;
        assign hit = wr_en && (wr_addr[0] == p[0]);

        // Write the selected per-port register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_o[p]   <= '0;
                mode_o[p] <= '0;
                def_o[p]  <= '0;
            end else if (hit) begin
                case (kind)
                    REG_ENABLE:  en_o[p]   <= wr_data;
                    REG_MODE:    mode_o[p] <= wr_data;
                    REG_DEFAULT: def_o[p]  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // Write the global configuration at address 6
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_o <= '0;
        else if (wr_en && kind == REG_CONFIG && !wr_addr[0])
            cfg_o <= ioc_cfg_t'(wr_data[CFGW-1:0]);
    end
endmodule

// File: rtl/ioc_port.sv
// Module ioc_port
// Per-port compare, flag and capture logic. A pin is compared either with
// its previous sample (mode bit 0) or with its default bit (mode bit 1).
// Assumes pin values are already synchronous to clk. A clear wins over a
// new condition in the same cycle.
module ioc_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] en,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] defval,
    input  logic         clr,
    output logic [W-1:0] flags,
    output logic [W-1:0] cap,
    output logic         irq
);
    logic [W-1:0] prev;
    logic [W-1:0] ref_val;
    logic [W-1:0] cond;

    // Select the comparison source for each pin
    assign ref_val = (mode & defval) | (~mode & prev);
    assign cond    = en & (pin ^ ref_val);
    assign irq     = |flags;

    // Remember last sample for change mode
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= pin;
    end

    // Sticky flags, cleared by a read
    always_ff @(posedge clk) begin
        if (!rst_n)   flags <= '0;
        else if (clr) flags <= '0;
        else          flags <= flags | cond;
    end

    // Capture the port when the first flag sets
    always_ff @(posedge clk) begin
        if (!rst_n)                      cap <= '0;
        else if (!clr && !irq && |cond)  cap <= pin;
    end

    a_r2_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(en)) == '0));
    a_r5_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> $stable(cap));
    a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> ((flags & $past(flags)) == $past(flags)));
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags == '0));
endmodule

// File: rtl/ioc_irq_drive.sv
// Module ioc_irq_drive
// Converts an interrupt state into pad controls. Open-drain pulls low
// only while asserted and ignores the active level. Push-pull always
// drives, with the level set by act_high.
module ioc_irq_drive (
    input  logic irq,
    input  logic open_drain,
    input  logic act_high,
    output logic oe,
    output logic val
);
    // Choose pad controls for the electrical mode
    always_comb begin
        if (open_drain) begin
            oe  = irq;
            val = 1'b0;
        end else begin
            oe  = 1'b1;
            val = act_high ? irq : ~irq;
        end
    end
endmodule

// File: rtl/port_ioc_unit.sv
// Module port_ioc_unit
// Interrupt-on-change unit for two ports. It instantiates the register
// file, one compare/capture slice per port and one pad driver per output.
// Output routing is optionally mirrored.
// Assumes synchronized, polarity-corrected pin inputs and one-cycle read
// strobes.
module port_ioc_unit
    import ioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_a,
    input  logic [W-1:0] pin_b,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         rd_cap_a,
    input  logic         rd_port_a,
    input  logic         rd_cap_b,
    input  logic         rd_port_b,
    output logic [W-1:0] flag_a,
    output logic [W-1:0] flag_b,
    output logic [W-1:0] cap_a,
    output logic [W-1:0] cap_b,
    output logic         irq_a_oe,
    output logic         irq_a_val,
    output logic         irq_b_oe,
    output logic         irq_b_val
);
    localparam int NPORT = 2;

    logic [NPORT-1:0][W-1:0] pins, en, mode, defv, flags, caps;
    logic [NPORT-1:0]        clr, irq_port, irq_out, oe, val;
    ioc_cfg_t                cfg;

    assign pins = {pin_b, pin_a};
    assign clr  = {rd_cap_b | rd_port_b, rd_cap_a | rd_port_a};

    ioc_cfg_regs #(.W(W), .NPORT(NPORT), .AW(3)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .en_o(en), .mode_o(mode), .def_o(defv),
        .cfg_o(cfg)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_slice
        ioc_port #(.W(W)) u_port (
            .clk(clk), .rst_n(rst_n), .pin(pins[p]), .en(en[p]),
            .mode(mode[p]), .defval(defv[p]), .clr(clr[p]),
            .flags(flags[p]), .cap(caps[p]), .irq(irq_port[p])
        );

        // Route own port or the OR of both ports
        assign irq_out[p] = cfg.mirror ? |irq_port : irq_port[p];

        ioc_irq_drive u_drive (
            .irq(irq_out[p]), .open_drain(cfg.open_drain),
            .act_high(cfg.act_high), .oe(oe[p]), .val(val[p])
        );
    end

    assign flag_a    = flags[0];
    assign flag_b    = flags[1];
    assign cap_a     = caps[0];
    assign cap_b     = caps[1];
    assign irq_a_oe  = oe[0];
    assign irq_a_val = val[0];
    assign irq_b_oe  = oe[1];
    assign irq_b_val = val[1];

    a_r7_mirror_equal: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.mirror |-> (irq_a_oe == irq_b_oe && irq_a_val == irq_b_val));
    a_r9_od_never_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.open_drain |-> !(oe[0] && val[0]) && !(oe[1] && val[1]));
endmodule

// File: tb/sim_port_ioc_unit.sv
// Directed bench for port_ioc_unit: one task per scenario.
module sim_port_ioc_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_a = '0, pin_b = '0, wr_data = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic       rd_cap_a = 1'b0, rd_port_a = 1'b0, rd_cap_b = 1'b0, rd_port_b = 1'b0;
    logic [7:0] flag_a, flag_b, cap_a, cap_b;
    logic       irq_a_oe, irq_a_val, irq_b_oe, irq_b_val;
    int         n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    port_ioc_unit u0 (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk); pin_a = a; pin_b = b;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flag_a", flag_a, 8'h00);
        chk("R1 cap_b", cap_b, 8'h00);
        chk("R1 irq_a oe/val", {6'd0, irq_a_oe, irq_a_val}, 8'h03);
        chk("R1 irq_b oe/val", {6'd0, irq_b_oe, irq_b_val}, 8'h03);
    endtask

    task automatic t_disabled;
        set_pins(8'hFF, 8'h00);
        chk("R2 flag_a no enable", flag_a, 8'h00);
        chk("R2 irq_a idle", {7'd0, irq_a_val}, 8'h01);
    endtask

    task automatic t_change_and_capture;
        wr(3'd0, 8'h01);              // R10: enable A, change mode
        set_pins(8'hFE, 8'h00);       // bit0 toggles
        chk("R3 flag_a", flag_a, 8'h01);
        chk("R5 cap_a", cap_a, 8'hFE);
        chk("R8 irq_a active low", {7'd0, irq_a_val}, 8'h00);
        chk("R7 irq_b not mirrored", {7'd0, irq_b_val}, 8'h01);
        set_pins(8'hFC, 8'h00);       // disabled bit1 changes
        chk("R2 flag_a bit1", flag_a, 8'h01);
        set_pins(8'hFD, 8'h00);       // bit0 back again
        chk("R3 sticky flag_a", flag_a, 8'h01);
        chk("R5 cap_a frozen", cap_a, 8'hFE);
        @(negedge clk); rd_cap_a = 1'b1;
        @(negedge clk); rd_cap_a = 1'b0;
        chk("R6 flag_a cleared", flag_a, 8'h00);
        chk("R6 irq_a released", {7'd0, irq_a_val}, 8'h01);
        @(negedge clk);
        chk("R3 no reassert", flag_a, 8'h00);
        chk("R5 cap_a kept", cap_a, 8'hFE);
    endtask

    task automatic t_default_mode;
        wr(3'd1, 8'h80);              // R10: enable B bit7
        wr(3'd3, 8'h80);              // R10: mode B bit7 = default compare
        chk("R4 match no flag", flag_b, 8'h00);
        set_pins(8'hFD, 8'h81);
        chk("R4 flag_b", flag_b, 8'h80);
        chk("R5 cap_b", cap_b, 8'h81);
        @(negedge clk); rd_port_b = 1'b1;
        @(negedge clk); rd_port_b = 1'b0;
        chk("R4 flag_b low after clear", flag_b, 8'h00);
        @(negedge clk);
        chk("R4 flag_b reasserted", flag_b, 8'h80);
        wr(3'd5, 8'h80);              // R10: default B bit7 = 1, now matches
        @(negedge clk); rd_port_b = 1'b1;
        @(negedge clk); rd_port_b = 1'b0;
        @(negedge clk);
        chk("R4 stays clear on match", flag_b, 8'h00);
        wr(3'd5, 8'h00);
        @(negedge clk);
        chk("R4 mismatch sets flag_b", flag_b, 8'h80);
    endtask

    task automatic t_clear_isolation;
        set_pins(8'hFC, 8'h81);       // A bit0 toggles, B stays flagged
        chk("R6 flag_a set", flag_a, 8'h01);
        @(negedge clk); rd_cap_a = 1'b1;
        @(negedge clk); rd_cap_a = 1'b0;
        chk("R6 flag_a cleared", flag_a, 8'h00);
        chk("R6 flag_b untouched", flag_b, 8'h80);
    endtask

    task automatic t_outputs;
        // Only B flagged now.
        chk("R7 a idle before mirror", {7'd0, irq_a_val}, 8'h01);
        wr(3'd6, 8'h01);              // R10: mirror
        chk("R7 mirror a", {7'd0, irq_a_val}, 8'h00);
        chk("R7 mirror b", {7'd0, irq_b_val}, 8'h00);
        wr(3'd6, 8'h04);              // R10: active-high, no mirror
        chk("R8 a inactive high", {6'd0, irq_a_oe, irq_a_val}, 8'h02);
        chk("R8 b active high", {6'd0, irq_b_oe, irq_b_val}, 8'h03);
        wr(3'd6, 8'h06);              // R10: open-drain + active-high
        chk("R9 a released", {6'd0, irq_a_oe, irq_a_val}, 8'h00);
        chk("R9 b pulls low", {6'd0, irq_b_oe, irq_b_val}, 8'h02);
        wr(3'd6, 8'h03);              // R10: open-drain + mirror
        chk("R9 R7 a pulls low", {6'd0, irq_a_oe, irq_a_val}, 8'h02);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_change_and_capture();
        t_default_mode();
        t_clear_isolation();
        t_outputs();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule